// File: doc/BRIEF.md
# Advanced-Load Address Conflict Table

This block lets a compiler schedule a load ahead of stores that might touch the same memory. When an advanced load issues, the table records the load's destination register tag together with the 8-byte granule its address falls in. Every store that follows is compared against all recorded granules, and each entry it matches becomes invalid.

Before the hoisted value is used, a check operation names the register. If that register still has a valid entry, the check succeeds and the speculative value stands. If it does not, the check fails and the pipeline must re-execute the load. The data cache and the re-execution are outside this block.

Allocation follows a fixed order. A register that already has an entry reuses it. Otherwise the load takes a free entry. When no entry is free, a round-robin pointer picks the entry to evict. A single clear input empties the whole table.

Top module: `adv_load_table`

## Requirements
- R1: After reset every entry is invalid, so a check of any register returns chk_ok = 0.
- R2: A check of a register whose entry is valid returns chk_ok = 1 in the same cycle as chk_en. A successful check leaves the entry valid, so a repeated check also succeeds.
- R3: chk_ok is 0 when chk_en is low. chk_ok is also 0 when the checked register has no valid entry.
- R4: A store invalidates every entry whose address bits [ADDR_W-1:3] equal those of the store address. An entry in a different 8-byte granule, including the granule next to it, stays valid.
- R5: A store and a check may hit the same entry in the same cycle. The store takes effect first, so that check returns 0.
- R6: An advanced load to a register that already has a valid entry overwrites that entry with the new address. The old address is no longer guarded, and no other entry is used or evicted.
- R7: A load to a new register takes the lowest-index free entry. When every entry is valid, it evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such an eviction.
- R8: clear_all invalidates all entries at the next edge. A check in the same cycle as clear_all returns 0.
- R9: A load and a store to the same granule in the same cycle leave the new entry valid, because the store is treated as older.
- R10: A check in the same cycle as a load to the same register sees the table state before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Invalidate every entry |
| ld_en | input | 1 | Advanced load issues this cycle |
| ld_reg | input | REG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Load byte address |
| st_en | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Store byte address |
| chk_en | input | 1 | Check operation this cycle |
| chk_reg | input | REG_W | Register tag being checked |
| chk_ok | output | 1 | Check succeeded (entry still valid) |

## Verification
The bench builds the table with ENTRIES = 4, REG_W = 7 and ADDR_W = 32. With four entries, a few loads fill the table, so the bench can follow round-robin eviction through two steps and watch a store-freed entry being reused ahead of the pointer. The 8-byte granule is kept, so stores one byte inside and one byte outside a recorded granule can be placed exactly. Same-cycle collisions are each driven in a single cycle: store with check, load with store, load with check, and clear with check.

// File: rtl/adv_load_table.sv
module adv_load_table #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              ld_en,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_en,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_ok
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = ADDR_W - GRAN_LG;

  logic [ENTRIES-1:0] vld;
  logic [REG_W-1:0]   rtag [ENTRIES];
  logic [TAG_W-1:0]   atag [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] st_kill, ld_same, chk_match;
  logic [IDX_W-1:0]   victim;
  logic               evict;

  wire [TAG_W-1:0] st_gran = st_addr[ADDR_W-1:GRAN_LG];
  wire [TAG_W-1:0] ld_gran = ld_addr[ADDR_W-1:GRAN_LG];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_kill[i]   = st_en && vld[i] && (atag[i] == st_gran);
      ld_same[i]   = vld[i] && (rtag[i] == ld_reg);
      chk_match[i] = vld[i] && (rtag[i] == chk_reg);
    end
  end

  always_comb begin
    victim = rr_ptr;
    evict  = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        victim = IDX_W'(i);
        evict  = 1'b0;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (ld_same[i]) begin
        victim = IDX_W'(i);
        evict  = 1'b0;
      end
  end

  assign chk_ok = chk_en && !clear_all && |(chk_match & ~st_kill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else if (clear_all) begin
      vld <= '0;
    end else begin
      vld <= vld & ~st_kill;
      if (ld_en) begin
        vld[victim]  <= 1'b1;
        rtag[victim] <= ld_reg;
        atag[victim] <= ld_gran;
        if (evict)
          rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  function automatic logic reg_present(logic [REG_W-1:0] r);
    logic f = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && rtag[i] == r) f = 1'b1;
    return f;
  endfunction

  function automatic logic gran_present(logic [TAG_W-1:0] g);
    logic f = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && atag[i] == g) f = 1'b1;
    return f;
  endfunction

  a_r6_unique_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_match));

  a_r2_load_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clear_all) |=> reg_present($past(ld_reg)));

  a_r4_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !clear_all && !(ld_en && ld_gran == st_gran))
      |=> !gran_present($past(st_gran)));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (vld == '0));

  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en || clear_all || !(&vld) || (|ld_same)) |=> $stable(rr_ptr));

  a_r5_store_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && (atag[victim] == st_gran) && chk_match[victim] && !ld_en) |-> !chk_ok);
endmodule

// File: tb/adv_load_table_tb.sv
`timescale 1ns/1ps
module adv_load_table_tb_top;
  localparam int ENTRIES = 4;
  localparam int REG_W   = 7;
  localparam int ADDR_W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_all = 1'b0;
  logic ld_en = 1'b0, st_en = 1'b0, chk_en = 1'b0;
  logic [REG_W-1:0] ld_reg = '0, chk_reg = '0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
  logic chk_ok;
  logic got;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adv_load_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_en(st_en), .st_addr(st_addr),
    .chk_en(chk_en), .chk_reg(chk_reg), .chk_ok(chk_ok));

  task automatic step(input logic l, input int lr, input int la,
                      input logic s, input int sa,
                      input logic c, input int cr, input logic cl);
    @(negedge clk);
    ld_en = l; ld_reg = REG_W'(lr); ld_addr = ADDR_W'(la);
    st_en = s; st_addr = ADDR_W'(sa);
    chk_en = c; chk_reg = REG_W'(cr); clear_all = cl;
    #1 got = chk_ok;
    @(posedge clk);
    #0.5;
    ld_en = 0; st_en = 0; chk_en = 0; clear_all = 0;
  endtask

  task automatic expect_ok(input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: chk_ok=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic load(input int r, input int a);
    step(1, r, a, 0, 0, 0, 0, 0);
  endtask
  task automatic store(input int a);
    step(0, 0, 0, 1, a, 0, 0, 0);
  endtask
  task automatic check(input int r, input logic exp, input string req);
    step(0, 0, 0, 0, 0, 1, r, 0);
    expect_ok(exp, req, $sformatf("check r%0d", r));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check(5, 0, "R1");
    check(0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 5, 0);
    expect_ok(0, "R3", "chk_en low");
  endtask

  task automatic t_basic();
    do_reset();
    load(10, 'h100);
    check(10, 1, "R2");
    check(10, 1, "R2 repeat");
    check(11, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 10, 0);
    expect_ok(0, "R3", "chk_en low with valid entry");
  endtask

  task automatic t_store();
    do_reset();
    load(10, 'h100);
    store('h104);
    check(10, 0, "R4");
    load(12, 'h200);
    store('h208);
    check(12, 1, "R4 next granule");
    store('h1FF);
    check(12, 1, "R4 previous granule");
    store('h207);
    check(12, 0, "R4 last byte");
  endtask

  task automatic t_store_check();
    do_reset();
    load(13, 'h300);
    step(0, 0, 0, 1, 'h302, 1, 13, 0);
    expect_ok(0, "R5", "store and check same cycle");
    check(13, 0, "R5 after");
  endtask

  task automatic t_overwrite();
    do_reset();
    load(20, 'h400);
    load(20, 'h500);
    store('h400);
    check(20, 1, "R6 old address unguarded");
    load(21, 'h600); load(22, 'h640); load(23, 'h680);
    check(20, 1, "R6 no entry consumed");
    check(21, 1, "R6");
    check(22, 1, "R6");
    check(23, 1, "R6");
    store('h500);
    check(20, 0, "R6 new address guarded");
  endtask

  task automatic t_replace();
    do_reset();
    load(1, 'h1000); load(2, 'h1040); load(3, 'h1080); load(4, 'h10C0);
    load(5, 'h2000);
    check(1, 0, "R7 evict entry0");
    check(2, 1, "R7");
    check(5, 1, "R7");
    load(6, 'h2040);
    check(2, 0, "R7 evict entry1");
    check(3, 1, "R7");
    store('h10C0);
    load(7, 'h2080);
    check(3, 1, "R7 free entry reused");
    check(5, 1, "R7");
    check(6, 1, "R7");
    check(7, 1, "R7");
    load(8, 'h20C0);
    check(3, 0, "R7 evict entry2");
    check(7, 1, "R7");
    check(8, 1, "R7");
  endtask

  task automatic t_clear();
    do_reset();
    load(9, 'h900);
    step(0, 0, 0, 0, 0, 1, 9, 1);
    expect_ok(0, "R8", "check with clear");
    check(9, 0, "R8 after clear");
  endtask

  task automatic t_collide();
    do_reset();
    step(1, 30, 'h700, 1, 'h704, 0, 0, 0);
    check(30, 1, "R9");
    step(1, 31, 'h800, 0, 0, 1, 31, 0);
    expect_ok(0, "R10", "check with load");
    check(31, 1, "R10 after");
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_store();
    t_store_check();
    t_overwrite();
    t_replace();
    t_clear();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule